// File: doc/BRIEF.md
# Length-Prefixed Serial Shift Engine

This block drives a single-lane SPI-style link. It produces chip select, serial clock and serial data out, and it samples serial data in. Commands reach it as a plain byte stream, and each transaction describes itself in that stream. Two header bytes come first. The first gives how many bits to send and the second gives how many bits to receive. The bytes that carry the bits to send follow the headers. Received bits are packed into bytes and leave on a separate output stream. The user therefore never sets a length register. A transaction of any bit length up to 255 out and 255 in is one burst of bytes.

A clock-enable input named `tick` advances the engine by one serial-clock half-period. The serial clock rate is set by how often the surrounding logic pulses `tick`. When a read follows the write, one extra serial clock pulse is inserted before the first bit is sampled. This turnaround pulse gives the device time to start driving its output. If the payload stream runs dry, or the output stream applies backpressure, the serial clock freezes in its current level until the engine can continue.

Top module: `bitlen_shift_engine`

## Requirements
- R1: While `rst_n` is low, `cs_n` is 1, `sck` is 0, `busy` is 0 and `out_valid` is 0.
- R2: The first accepted byte of a transaction is the write bit count and the second is the read bit count. Both are taken while `cs_n` is still 1.
- R3: Write bits are sent most significant bit first from the payload bytes that follow the headers. Exactly ceil(write count / 8) payload bytes are consumed. Unused low bits of the last payload byte are discarded.
- R4: For every write bit, `mosi` changes only while `sck` is 0 and `cs_n` is 0. `sck` then rises, and `mosi` holds steady while `sck` is 1.
- R5: When the read count is 0, the transaction ends right after the high phase of the last write bit. The number of `sck` rising edges while selected equals the write count.
- R6: When the read count is nonzero, one unsampled `sck` pulse follows the write bits. Rising edges while selected then total write count + 1 + read count.
- R7: Each read bit is sampled from `miso` at the end of an `sck`-low phase. `sck` then rises. Bits fill a byte from bit 7 downward, and each full byte is pushed on `out_data`. A final partial byte is pushed with its bits at the top and zeros below.
- R8: At the end of a transaction, `cs_n` rises while `sck` is 1. `sck` stays 1 for one tick period before the next header is accepted.
- R9: `sck` and `cs_n` change only on clock edges where `tick` was 1.
- R10: If a payload byte is needed but `in_valid` is 0, the engine waits. It also waits when a received byte cannot be placed because `out_valid` is 1 and `out_ready` is 0. In both cases `sck` holds its level and `cs_n` stays 0.
- R11: `busy` is 1 from the acceptance of the first header byte until `cs_n` rises. It is 1 whenever `cs_n` is 0 and is 0 once the transaction closes.
- R12: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Clock enable, one serial-clock half-period per pulse |
| in_valid | input | 1 | Command/payload byte available |
| in_data | input | W | Header or payload byte |
| in_ready | output | 1 | Byte accepted on this edge when `in_valid` is 1 |
| out_valid | output | 1 | Received byte available |
| out_data | output | W | Received byte, first bit in bit W-1 |
| out_ready | input | 1 | Consumer takes `out_data` |
| cs_n | output | 1 | Active-low chip select |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to device |
| miso | input | 1 | Serial data from device |
| busy | output | 1 | Transaction in progress |

## Verification
The bound checker covers the cycle-level rules on every clock. It checks that `sck` and `cs_n` move only after a tick and that `mosi` never moves while `sck` is high. It also checks that chip select always releases with `sck` high, that `busy` covers every selected cycle, and that a held output byte stays frozen. Other behaviours can only be shown by the bench's scenarios, which compare whole transactions against a device model. These are the bit order of written and received data, the exact payload byte consumption, the presence of the turnaround pulse, the zero-fill of a partial last byte, and the pulse count when the read length is zero. The bench also holds back a payload byte and the output handshake to show the serial clock parking in mid-transaction.

// File: rtl/bse_pkg.sv
package bse_pkg;

    typedef enum logic [3:0] {
        ST_HDR0,   // waiting for write bit count
        ST_HDR1,   // waiting for read bit count
        ST_ARM,    // headers taken, deciding first phase
        ST_WLO,    // write bit presented, clock low
        ST_WHI,    // write bit captured by device, clock high
        ST_TLO,    // turnaround pulse, low half
        ST_THI,    // turnaround pulse, high half
        ST_RLO,    // read bit window, clock low
        ST_RHI,    // read bit done, clock high
        ST_DONE    // select released, clock parked high
    } bse_state_e;

    function automatic logic cs_n_of(bse_state_e s);
        return s inside {ST_HDR0, ST_HDR1, ST_ARM, ST_DONE};
    endfunction

    function automatic logic sck_of(bse_state_e s);
        return s inside {ST_WHI, ST_THI, ST_RHI, ST_DONE};
    endfunction

    function automatic logic busy_of(bse_state_e s);
        return !(s inside {ST_HDR0, ST_DONE});
    endfunction

endpackage

// File: rtl/bse_tx_shift.sv
module bse_tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         emit,
    input  logic [W-1:0] load_data,
    output logic         need_byte,
    output logic         mosi
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [CW-1:0] left;
        logic          bit_q;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d = q;
        if (flush) begin
            d.sh   = '0;
            d.left = '0;
        end else if (emit) begin
            if (q.left == '0) begin
                d.bit_q = load_data[W-1];
                d.sh    = load_data << 1;
                d.left  = CW'(W - 1);
            end else begin
                d.bit_q = q.sh[W-1];
                d.sh    = q.sh << 1;
                d.left  = q.left - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign need_byte = (q.left == '0);
    assign mosi      = q.bit_q;

endmodule

// File: rtl/bse_rx_pack.sv
module bse_rx_pack #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         sample,
    input  logic         bit_in,
    input  logic         last,
    input  logic         out_ready,
    output logic         can_take,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    localparam int IW = $clog2(W);

    typedef struct packed {
        logic [W-1:0]  acc;
        logic [IW-1:0] idx;
        logic          vld;
        logic [W-1:0]  data;
    } rx_t;

    rx_t q, d;
    logic [W-1:0]  merged;
    logic [IW-1:0] pos;
    logic          closing;

    always_comb begin
        pos         = IW'(W - 1) - q.idx;
        merged      = q.acc;
        merged[pos] = bit_in;
        closing     = (q.idx == IW'(W - 1)) || last;

        d = q;
        if (q.vld && out_ready) d.vld = 1'b0;
        if (flush) begin
            d.acc = '0;
            d.idx = '0;
        end else if (sample) begin
            if (closing) begin
                d.data = merged;
                d.vld  = 1'b1;
                d.acc  = '0;
                d.idx  = '0;
            end else begin
                d.acc = merged;
                d.idx = q.idx + IW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign can_take  = !closing || !q.vld || out_ready;
    assign out_valid = q.vld;
    assign out_data  = q.data;

endmodule

// File: rtl/bitlen_shift_engine.sv
module bitlen_shift_engine
    import bse_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_ready,
    output logic         cs_n,
    output logic         sck,
    output logic         mosi,
    input  logic         miso,
    output logic         busy
);
    typedef struct packed {
        bse_state_e   st;
        logic [W-1:0] out_rem;
        logic [W-1:0] in_rem;
        logic         cs_n;
        logic         sck;
        logic         busy;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{st: ST_HDR0, out_rem: '0, in_rem: '0,
                                   cs_n: 1'b1, sck: 1'b0, busy: 1'b0};

    ctl_t q, d;
    logic tx_emit, tx_flush, tx_need;
    logic rx_sample, rx_flush, rx_can_take, rx_last;

    always_comb begin
        d         = q;
        in_ready  = 1'b0;
        tx_emit   = 1'b0;
        tx_flush  = 1'b0;
        rx_sample = 1'b0;
        rx_flush  = 1'b0;
        rx_last   = (q.in_rem == W'(1));

        unique case (q.st)
            ST_HDR0: begin
                in_ready = tick;
                if (tick && in_valid) begin
                    d.out_rem = in_data;
                    d.st      = ST_HDR1;
                end
            end
            ST_HDR1: begin
                in_ready = tick;
                if (tick && in_valid) begin
                    d.in_rem = in_data;
                    tx_flush = 1'b1;
                    rx_flush = 1'b1;
                    d.st     = ST_ARM;
                end
            end
            ST_ARM, ST_WHI: begin
                if (tick) begin
                    if (q.out_rem != '0) begin
                        in_ready = tx_need;
                        if (!tx_need || in_valid) begin
                            tx_emit   = 1'b1;
                            d.out_rem = q.out_rem - W'(1);
                            d.st      = ST_WLO;
                        end
                    end else if (q.in_rem != '0) begin
                        d.st = ST_TLO;
                    end else begin
                        d.st = ST_DONE;
                    end
                end
            end
            ST_WLO: if (tick) d.st = ST_WHI;
            ST_TLO: if (tick) d.st = ST_THI;
            ST_THI: if (tick) d.st = ST_RLO;
            ST_RLO: begin
                if (tick && rx_can_take) begin
                    rx_sample = 1'b1;
                    d.in_rem  = q.in_rem - W'(1);
                    d.st      = ST_RHI;
                end
            end
            ST_RHI: begin
                if (tick) d.st = (q.in_rem != '0) ? ST_RLO : ST_DONE;
            end
            ST_DONE: if (tick) d.st = ST_HDR0;
            default: d.st = ST_HDR0;
        endcase

        d.cs_n = cs_n_of(d.st);
        d.sck  = sck_of(d.st);
        d.busy = busy_of(d.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RESET;
        else        q <= d;
    end

    bse_tx_shift #(.W(W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .emit      (tx_emit),
        .load_data (in_data),
        .need_byte (tx_need),
        .mosi      (mosi)
    );

    bse_rx_pack #(.W(W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .sample    (rx_sample),
        .bit_in    (miso),
        .last      (rx_last),
        .out_ready (out_ready),
        .can_take  (rx_can_take),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    assign cs_n = q.cs_n;
    assign sck  = q.sck;
    assign busy = q.busy;

endmodule

// File: rtl/bse_sva.sv
module bse_sva #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         cs_n,
    input logic         sck,
    input logic         mosi,
    input logic         busy,
    input logic         out_valid,
    input logic         out_ready,
    input logic [W-1:0] out_data
);
    // R9: serial pins move only after a tick
    a_r9_pins_need_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(sck) && $stable(cs_n)));

    // R4: data line settles only in the clock-low phase
    a_r4_mosi_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi) |-> !sck);

    // R8: select releases with the clock parked high
    a_r8_release_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> sck);

    // R11: busy covers every selected cycle
    a_r11_busy_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    // R12: an unaccepted output byte is frozen
    a_r12_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind bitlen_shift_engine bse_sva #(.W(W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cs_n      (cs_n),
    .sck       (sck),
    .mosi      (mosi),
    .busy      (busy),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/bitlen_shift_engine_tb.sv
module bitlen_shift_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic out_ready = 1'b0;
    logic miso = 1'b0;
    logic in_ready, out_valid, cs_n, sck, mosi, busy;
    logic [W-1:0] out_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bitlen_shift_engine #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso), .busy(busy)
    );

    int compared = 0;
    int mismatched = 0;

    logic [7:0] in_q[$];
    logic [7:0] got_q[$];
    logic [7:0] txn_bytes[$];
    logic [7:0] pay[$];
    logic       wr_bits[$];
    logic       rd_bits[$];

    int cur_w = 0, cur_r = 0, k_edges = 0, last_edges = 0, done_cnt = 0;
    bit hold_out = 0, mon_on = 0;
    logic p_sck, p_cs, p_mosi, p_ov, p_or, last_tick;
    logic [7:0] p_od;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // Per-cycle monitor, device model and stream drivers, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mon_on) begin
                if (!last_tick && (sck !== p_sck || cs_n !== p_cs))
                    chk(1'b0, "R9 pin moved without tick", int'(sck), int'(p_sck));
                if (sck && p_sck && !cs_n && mosi !== p_mosi)
                    chk(1'b0, "R4 mosi moved while sck high", int'(mosi), int'(p_mosi));
                if (!cs_n && !busy)
                    chk(1'b0, "R11 busy low while selected", int'(busy), 1);
                if (p_ov && !p_or)
                    chk(out_valid && out_data == p_od, "R12 held output changed",
                        int'(out_data), int'(p_od));
                if (!cs_n && sck && !p_sck) begin
                    if (k_edges < cur_w) wr_bits.push_back(mosi);
                    k_edges++;
                    if (k_edges > cur_w && k_edges - cur_w - 1 < cur_r)
                        miso = rd_bits[k_edges - cur_w - 1];
                end
                if (cs_n && !p_cs) begin
                    chk(sck == 1'b1, "R8 sck at select release", int'(sck), 1);
                    chk(busy == 1'b0, "R11 busy after release", int'(busy), 0);
                    last_edges = k_edges;
                    k_edges = 0;
                    done_cnt++;
                end
            end
            p_sck = sck; p_cs = cs_n; p_mosi = mosi; p_ov = out_valid; p_od = out_data;

            tick      = ($urandom_range(0, 9) < 6);
            in_valid  = (in_q.size() > 0) && ($urandom_range(0, 9) < 8);
            in_data   = in_valid ? in_q[0] : 8'h00;
            out_ready = !hold_out && ($urandom_range(0, 9) < 7);
            #1;
            if (in_valid && in_ready) void'(in_q.pop_front());
            if (out_valid && out_ready) got_q.push_back(out_data);
            last_tick = tick;
            p_or = out_ready;
        end
    end

    task automatic begin_txn(input int w, input int r);
        logic [7:0] b;
        cur_w = w; cur_r = r;
        wr_bits.delete(); rd_bits.delete(); pay.delete(); got_q.delete(); txn_bytes.delete();
        txn_bytes.push_back(8'(w));
        txn_bytes.push_back(8'(r));
        for (int i = 0; i < (w + 7) / 8; i++) begin
            b = 8'($urandom);
            pay.push_back(b);
            txn_bytes.push_back(b);
        end
        for (int i = 0; i < r; i++) rd_bits.push_back(1'($urandom_range(0, 1)));
    endtask

    task automatic push_n(input int n);
        for (int i = 0; i < n; i++)
            if (txn_bytes.size() > 0) in_q.push_back(txn_bytes.pop_front());
    endtask

    task automatic finish_txn(input string tag);
        int start, nexp, cyc, bad, exp_edges;
        logic [7:0] eb;
        start = done_cnt;
        nexp = (cur_r + 7) / 8;
        cyc = 0;
        push_n(txn_bytes.size());
        while ((done_cnt == start || got_q.size() < nexp) && cyc < 40000) begin
            @(posedge clk);
            cyc++;
        end
        @(negedge clk); #2;
        chk(done_cnt > start, {"R5 transaction closes: ", tag}, done_cnt - start, 1);
        // R3: bits sent MSB first from the payload
        bad = 0;
        if (wr_bits.size() != cur_w) bad++;
        else for (int i = 0; i < cur_w; i++)
            if (wr_bits[i] !== pay[i / 8][7 - (i % 8)]) bad++;
        chk(bad == 0, {"R3 write bit order: ", tag}, bad, 0);
        chk(in_q.size() == 0, {"R3 payload fully consumed: ", tag}, in_q.size(), 0);
        // R2 header order, R5 / R6 pulse count
        exp_edges = cur_w + ((cur_r > 0) ? cur_r + 1 : 0);
        if (cur_r == 0)
            chk(last_edges == exp_edges, {"R5 write-only pulse count: ", tag}, last_edges, exp_edges);
        else
            chk(last_edges == exp_edges, {"R2,R6 pulse count with turnaround: ", tag}, last_edges, exp_edges);
        // R7: packed received bytes
        bad = 0;
        if (got_q.size() != nexp) bad++;
        else for (int j = 0; j < nexp; j++) begin
            eb = 8'h00;
            for (int t = 0; t < 8; t++)
                if (8 * j + t < cur_r) eb[7 - t] = rd_bits[8 * j + t];
            if (got_q[j] !== eb) bad++;
        end
        chk(bad == 0, {"R7 received bytes: ", tag}, bad, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "R5 watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (4) @(posedge clk);
        @(negedge clk); #2;
        chk(cs_n == 1'b1, "R1 cs_n in reset", int'(cs_n), 1);
        chk(sck == 1'b0, "R1 sck in reset", int'(sck), 0);
        chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
        chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        @(negedge clk); #3;
        rst_n = 1'b1;
        mon_on = 1;

        // R11 / R2: one header byte taken, still deselected
        begin_txn(8, 8);
        push_n(1);
        repeat (30) @(posedge clk);
        @(negedge clk); #2;
        chk(busy == 1'b1, "R11 busy after first header byte", int'(busy), 1);
        chk(cs_n == 1'b1, "R2 select high during headers", int'(cs_n), 1);
        finish_txn("split header");

        // R10: payload underflow parks sck high mid-write
        begin_txn(16, 0);
        push_n(3);
        repeat (80) @(posedge clk);
        @(negedge clk); #2;
        chk(!cs_n && sck && k_edges == 8, "R10 payload stall", k_edges, 8);
        finish_txn("payload stall");

        // R10: output backpressure parks sck low before the blocked sample
        hold_out = 1;
        begin_txn(0, 24);
        push_n(2);
        repeat (200) @(posedge clk);
        @(negedge clk); #2;
        chk(!cs_n && !sck && out_valid && k_edges == 16, "R10 output stall", k_edges, 16);
        hold_out = 0;
        finish_txn("output stall");

        begin_txn(255, 0); finish_txn("max write");
        begin_txn(0, 255); finish_txn("max read");
        begin_txn(1, 1);   finish_txn("single bits");
        begin_txn(7, 9);   finish_txn("7 out 9 in");
        begin_txn(9, 7);   finish_txn("9 out 7 in");
        begin_txn(8, 0);   finish_txn("byte write only");
        begin_txn(0, 8);   finish_txn("byte read only");

        for (int n = 0; n < 30; n++) begin
            int w, r;
            w = $urandom_range(0, 40);
            r = $urandom_range(0, 40);
            if (w == 0 && r == 0) w = 1;
            begin_txn(w, r);
            finish_txn("random");
        end

        summary();
        $finish;
    end

endmodule